// File: doc/BRIEF.md
# Integer ALU with Overflow Detection

This block is the combinational arithmetic-logic unit of a small load/store processor. It takes two operands and a 4-bit operation code from the instruction decoder. It returns a result word and two flags. The zero flag is high when the result is all zeros. The overflow flag reports signed overflow of an add or a subtract.

The block has two parts under a thin top. A small decoder turns the operation code into a set of strobes. These strobes are: invert operand B, drive the carry-in, pick the result source, and enable the overflow flag. A datapath holds the ripple-carry adder chain, the bitwise logic, the result multiplexer and the flag logic.

Subtraction adds the inverted B operand with a carry-in of one. Overflow compares the carry that enters the top bit position with the carry that leaves it. Set-on-less-than folds that overflow indication into the sign of the difference, so the comparison stays correct when the subtraction wraps.

Top module: `alu_core`

## Requirements
- R1: Code 4'b0000 returns the bitwise AND of the two operands.
- R2: Code 4'b0001 returns the bitwise OR of the two operands.
- R3: Code 4'b0010 returns the two operands added, modulo 2^32.
- R4: Code 4'b0110 returns A minus B, modulo 2^32. It is computed as A plus the inverted B plus one.
- R5: Code 4'b0111 returns 1 in bit 0 and zeros in every other bit when A is less than B as signed two's-complement numbers. Otherwise it returns all zeros. This holds also when A minus B overflows.
- R6: For add or subtract, overflow is high when the top bit position takes in a carry but gives none out. This is the case of two positive addends giving a negative result.
- R7: For add or subtract, overflow is high when the top bit position gives out a carry but took none in. This is the case of two negative addends giving a positive result.
- R8: Overflow is low whenever the carry into and the carry out of the top bit are equal. It is also low for AND, OR and set-on-less-than.
- R9: The zero flag is high exactly when all 32 result bits are zero.
- R10: Any code other than the five above returns a result of zero, with the zero flag high and overflow low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| opSel | input | 4 | Operation code from the instruction decoder |
| result | output | 32 | Operation result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |

## Verification
The logic operations are tried with interleaved nibble patterns, so a swapped AND/OR source or a stuck bit shows up in a different place for each operation.

Add and subtract are tried with four kinds of carry into and out of the top bit position:
- small values, where neither carry is set;
- all-ones plus one, where both carries are set;
- largest positive plus one, where only the carry in is set;
- most negative plus most negative, where only the carry out is set.

These four cases separate a correct carry-compare overflow from one built on a single carry.

Set-on-less-than is tried on pairs where the difference overflows and on pairs where it does not. A comparison that reads only the sign bit fails on the overflowing pairs.

A stream of pseudo-random operands across all codes, unused codes included, is compared against a signed-arithmetic model.

// File: rtl/alu_pkg.sv
package alu_pkg;

  localparam int WIDTH = 32;
  localparam int SEL_W = 4;

  localparam logic [SEL_W-1:0] OP_AND = 4'b0000;
  localparam logic [SEL_W-1:0] OP_OR  = 4'b0001;
  localparam logic [SEL_W-1:0] OP_ADD = 4'b0010;
  localparam logic [SEL_W-1:0] OP_SUB = 4'b0110;
  localparam logic [SEL_W-1:0] OP_SLT = 4'b0111;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_AND  = 3'd1,
    SRC_OR   = 3'd2,
    SRC_SUM  = 3'd3,
    SRC_LESS = 3'd4
  } resSrc_t;

  typedef struct packed {
    logic    invertB;
    logic    carryIn;
    logic    ovfEnable;
    resSrc_t resSrc;
  } aluStrobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import alu_pkg::*;
#(
  parameter int SelW = SEL_W
) (
  input  logic [SelW-1:0] opSel,
  output aluStrobes_t     strobes
);

  always_comb begin
    strobes = '{invertB: 1'b0, carryIn: 1'b0, ovfEnable: 1'b0, resSrc: SRC_NONE};
    unique case (opSel)
      OP_AND: strobes.resSrc = SRC_AND;
      OP_OR:  strobes.resSrc = SRC_OR;
      OP_ADD: begin
        strobes.resSrc    = SRC_SUM;
        strobes.ovfEnable = 1'b1;
      end
      OP_SUB: begin
        strobes.resSrc    = SRC_SUM;
        strobes.invertB   = 1'b1;
        strobes.carryIn   = 1'b1;
        strobes.ovfEnable = 1'b1;
      end
      OP_SLT: begin
        strobes.resSrc  = SRC_LESS;
        strobes.invertB = 1'b1;
        strobes.carryIn = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int Width = 32
) (
  input  logic [Width-1:0] addA,
  input  logic [Width-1:0] addB,
  input  logic             carryIn,
  output logic [Width-1:0] sum,
  output logic             carryTop,
  output logic             carryOut
);

  logic [Width:0] carry;

  assign carry[0] = carryIn;

  for (genvar i = 0; i < Width; i++) begin : g_bit
    assign sum[i]     = addA[i] ^ addB[i] ^ carry[i];
    assign carry[i+1] = (addA[i] & addB[i]) | ((addA[i] ^ addB[i]) & carry[i]);
  end

  assign carryTop = carry[Width-1];
  assign carryOut = carry[Width];

  always_comb begin
    AST_ADDER_SUM: assert ({carryOut, sum} ==
                           ({1'b0, addA} + {1'b0, addB} + {{Width{1'b0}}, carryIn})); // R3
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import alu_pkg::*;
#(
  parameter int Width = WIDTH
) (
  input  logic [Width-1:0] opA,
  input  logic [Width-1:0] opB,
  input  aluStrobes_t      strobes,
  output logic [Width-1:0] result,
  output logic             zero,
  output logic             overflow
);

  localparam int Msb = Width - 1;

  logic [Width-1:0] bEff;
  logic [Width-1:0] sum;
  logic             carryTop;
  logic             carryOut;
  logic             rawOvf;
  logic             lessBit;

  assign bEff = strobes.invertB ? ~opB : opB;

  alu_adder #(.Width(Width)) adder_i (
    .addA     (opA),
    .addB     (bEff),
    .carryIn  (strobes.carryIn),
    .sum      (sum),
    .carryTop (carryTop),
    .carryOut (carryOut)
  );

  assign rawOvf   = carryTop ^ carryOut;
  assign lessBit  = sum[Msb] ^ rawOvf;
  assign overflow = strobes.ovfEnable & rawOvf;

  always_comb begin
    unique case (strobes.resSrc)
      SRC_AND:  result = opA & opB;
      SRC_OR:   result = opA | opB;
      SRC_SUM:  result = sum;
      SRC_LESS: result = {{(Width-1){1'b0}}, lessBit};
      default:  result = '0;
    endcase
  end

  assign zero = ~|result;

  always_comb begin
    AST_OVF_SIGNS: assert (overflow == (strobes.ovfEnable && (opA[Msb] == bEff[Msb]) &&
                                        (sum[Msb] != opA[Msb]))); // R6
    if (strobes.resSrc == SRC_LESS) begin
      AST_SLT_SIGNED: assert (result[0] == ($signed(opA) < $signed(opB))); // R5
    end
    if (!strobes.ovfEnable) begin
      AST_NO_OVERFLOW: assert (!overflow); // R8
    end
  end

endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int Width = WIDTH,
  parameter int SelW  = SEL_W
) (
  input  logic [Width-1:0] opA,
  input  logic [Width-1:0] opB,
  input  logic [SelW-1:0]  opSel,
  output logic [Width-1:0] result,
  output logic             zero,
  output logic             overflow
);

  aluStrobes_t strobes;

  alu_ctrl #(.SelW(SelW)) ctrl_i (
    .opSel   (opSel),
    .strobes (strobes)
  );

  alu_datapath #(.Width(Width)) datapath_i (
    .opA      (opA),
    .opB      (opB),
    .strobes  (strobes),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  always_comb begin
    if (!(opSel inside {OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT})) begin
      AST_UNDEF_CODE: assert (result == '0 && zero && !overflow); // R10
    end
  end

endmodule

// File: tb/alu_core_tb_top.sv
module alu_core_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;
  localparam int NRAND = 60;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [3:0]  opSel = '0;
  logic [31:0] result;
  logic        zero;
  logic        overflow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alu_core dut_i (
    .opA      (opA),
    .opB      (opB),
    .opSel    (opSel),
    .result   (result),
    .zero     (zero),
    .overflow (overflow)
  );

  // {opSel, opA, opB, expected result, expected zero, expected overflow}
  localparam logic [101:0] VECS [NVEC] = '{
    {4'b0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 1'b0, 1'b0}, // R1
    {4'b0001, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 1'b0, 1'b0}, // R2
    {4'b0010, 32'h00000005, 32'h00000007, 32'h0000000C, 1'b0, 1'b0}, // R3
    {4'b0010, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b1}, // R6
    {4'b0010, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b1}, // R7 R9
    {4'b0010, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b1, 1'b0}, // R8 R9
    {4'b0110, 32'h00000010, 32'h00000003, 32'h0000000D, 1'b0, 1'b0}, // R4
    {4'b0110, 32'h00000003, 32'h00000003, 32'h00000000, 1'b1, 1'b0}, // R4 R9
    {4'b0110, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b1}, // R7
    {4'b0110, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b0, 1'b1}, // R6
    {4'b0111, 32'h80000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0}, // R5 R8
    {4'b0111, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0}, // R5
    {4'b0111, 32'hFFFFFFFE, 32'hFFFFFFFF, 32'h00000001, 1'b0, 1'b0}, // R5
    {4'b1111, 32'h00001234, 32'h00005678, 32'h00000000, 1'b1, 1'b0}, // R10
    {4'b0000, 32'h7FFFFFFF, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b0, 1'b0}, // R8
    {4'b0011, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b1, 1'b0}  // R10
  };

  task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got res=%h z=%b ovf=%b, expected res=%h z=%b ovf=%b",
               req, got[33:2], got[1], got[0], exp[33:2], exp[1], exp[0]);
    end
  endtask

  task automatic apply(input logic [3:0] s, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    #1;
    opSel = s;
    opA   = a;
    opB   = b;
    @(negedge clk);
  endtask

  function automatic logic [33:0] model(input logic [3:0] s, input logic [31:0] a,
                                        input logic [31:0] b);
    logic [31:0] r;
    logic        v;
    r = '0;
    v = 1'b0;
    case (s)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b0010: begin
        r = a + b;
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      4'b0110: begin
        r = a - b;
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      4'b0111: r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: r = '0;
    endcase
    return {r, (r == 32'd0), v};
  endfunction

  initial begin
    logic [31:0] lfsr;
    logic [3:0]  codes [8];
    codes = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b0100, 4'b1000, 4'b1110};
    lfsr = 32'hACE1_2468;

    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // Idle state: AND of zeros (R1, R9)
    check("R9 idle", {result, zero, overflow}, {32'd0, 1'b1, 1'b0});

    for (int i = 0; i < NVEC; i++) begin
      apply(VECS[i][101:98], VECS[i][97:66], VECS[i][65:34]);
      check($sformatf("table[%0d]", i), {result, zero, overflow}, VECS[i][33:0]);
    end

    // Random patterns across all codes: R1 R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int k = 0; k < NRAND; k++) begin
      logic [31:0] a;
      logic [31:0] b;
      logic [3:0]  s;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr ^ {lfsr[15:0], lfsr[31:16]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (k % 4 == 0) ? a : lfsr * 32'h9E3779B1;
      s = codes[k % 8];
      apply(s, a, b);
      check($sformatf("random R1..R10 sel=%b", s), {result, zero, overflow}, model(s, a, b));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule